// File: doc/BRIEF.md
# Stream-Detecting Cache Prefetcher

This block sits beside a cache and watches its demand accesses. It keeps a small table of candidate streams. Each candidate learns whether the accesses near it climb or fall through memory one cache block at a time. Once a candidate has learned a direction, an access that falls inside its tracked window triggers a burst of block-aligned prefetch addresses just beyond the far edge of the window. The window then moves forward by the length of that burst.

Accesses arrive on a valid/ready port. Prefetch addresses leave on a second valid/ready port, one per cycle, through a small internal buffer. The access port is held off while the buffer cannot take a whole burst, so no access is ever dropped. Table size, burst length (degree), window distance, block size and buffer depth are parameters. The defaults are 8 entries, degree 4, distance 5, 64-byte blocks and an 8-deep buffer.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0, `acc_ready` is 1, every entry is idle, and entry i holds age rank i.
- R2: The low log2(BLK_BYTES) bits of `acc_addr` are ignored. Every comparison and every computed address uses the block address, which is the access address with those bits cleared.
- R3: A training entry counts an access only if its block address lies within (DISTANCE/2) blocks of the entry's seed address. The vote is "up" if the block is above the seed and "down" otherwise. When the second vote agrees with the first, the entry becomes watching in that direction, with start = seed and end = block ± DEGREE blocks. No prefetch is issued before that.
- R4: If the second vote disagrees with the first, the entry returns to idle and no prefetch ever comes from it.
- R5: An upward watching entry hits only when start < block < end (strict). On a hit it emits end+1·B, end+2·B, … end+DEGREE·B in that order, where B = BLK_BYTES.
- R6: A downward watching entry hits only when start > block > end (strict). On a hit it emits end−1·B … end−DEGREE·B in that order.
- R7: After a hit, the new end is end ± DEGREE·B. If the distance from start to the new end is at most DISTANCE blocks, start stays; otherwise start moves by DEGREE·B in the same direction.
- R8: An access that hits no entry seeds a training entry at its block address. The entry chosen is the lowest-index idle entry, or the entry with rank ENTRIES−1 if none is idle. After every accepted access the entry used gets rank 0, and the entries ranked below its old rank age by one, so the ranks stay a permutation of 0..ENTRIES−1.
- R9: When several entries match, only the lowest-index one is updated, and a hit never seeds a new entry.
- R10: A prefetch address that would wrap below zero or past the top of the address space is not emitted. The other addresses of the burst still are.
- R11: `pf_addr` and `pf_valid` hold while `pf_valid` is high and `pf_ready` is low. `acc_ready` is low whenever fewer than DEGREE buffer slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Demand access present |
| acc_ready | output | 1 | Access accepted this cycle when high |
| acc_addr | input | ADDR_W | Byte address of the demand access |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | ADDR_W | Block-aligned prefetch address |

## Verification
Several properties are checked by assertions on every cycle:
- the age ranks remain a permutation, and the entry just used carries rank 0;
- the output buffer never exceeds its depth;
- the buffer fills only after an accepted access;
- a stalled prefetch address holds steady.

Other behaviours can only be shown by the bench's scenarios. These are direction learning, rejection of a disagreeing vote, strict window bounds, window sliding, LRU eviction order, lowest-index priority and suppression of wrapped addresses. Each scenario compares the exact emitted address sequence against expectations worked out by hand. Random stream walks are compared against a behavioural table model.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // Life cycle of one stream table entry
  typedef enum logic [1:0] {
    ENT_IDLE  = 2'd0,
    ENT_TRAIN = 2'd1,
    ENT_WATCH = 2'd2
  } ent_state_e;

endpackage

// File: rtl/spf_table.sv
module spf_table
  import spf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 8,
  parameter int DEGREE    = 4,
  parameter int DISTANCE  = 5,
  parameter int BLK_BYTES = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_fire,
  input  logic [ADDR_W-1:0]              acc_addr,
  output logic [DEGREE-1:0]              burst_vld,
  output logic [DEGREE-1:0][ADDR_W-1:0]  burst_addr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [ADDR_W-1:0] OFF_MASK   = ADDR_W'(BLK_BYTES - 1);
  localparam logic [ADDR_W-1:0] TRAIN_SPAN = ADDR_W'((DISTANCE / 2) * BLK_BYTES);
  localparam logic [ADDR_W-1:0] DIST_SPAN  = ADDR_W'(DISTANCE * BLK_BYTES);
  localparam logic [IDX_W-1:0]  OLDEST     = IDX_W'(ENTRIES - 1);

  // ---------------- arithmetic helpers ----------------
  function automatic logic [ADDR_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a & ~OFF_MASK;
  endfunction

  function automatic logic near_seed(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] seed);
    logic [ADDR_W-1:0] diff;
    diff = (a > seed) ? a - seed : seed - a;
    return diff <= TRAIN_SPAN;
  endfunction

  function automatic logic inside_win(input logic up, input logic [ADDR_W-1:0] s,
                                      input logic [ADDR_W-1:0] e, input logic [ADDR_W-1:0] a);
    return up ? ((s < a) && (a < e)) : ((s > a) && (a > e));
  endfunction

  // k blocks away, extra top bit flags a wrap past either end
  function automatic logic [ADDR_W:0] step_blk(input logic up, input logic [ADDR_W-1:0] base,
                                               input int unsigned k);
    logic [ADDR_W:0] delta;
    delta = (ADDR_W+1)'(k) * (ADDR_W+1)'(BLK_BYTES);
    return up ? ({1'b0, base} + delta) : ({1'b0, base} - delta);
  endfunction

  // k blocks away, modular
  function automatic logic [ADDR_W-1:0] step_mod(input logic up, input logic [ADDR_W-1:0] base,
                                                 input int unsigned k);
    logic [ADDR_W-1:0] delta;
    delta = ADDR_W'(k) * ADDR_W'(BLK_BYTES);
    return up ? (base + delta) : (base - delta);
  endfunction

  // ---------------- table state ----------------
  ent_state_e        st_q    [ENTRIES];
  logic [ADDR_W-1:0] seed_q  [ENTRIES];
  logic [ADDR_W-1:0] start_q [ENTRIES];
  logic [ADDR_W-1:0] end_q   [ENTRIES];
  logic [IDX_W-1:0]  rank_q  [ENTRIES];
  logic [ENTRIES-1:0] up_q, vote0_vld_q, vote0_up_q;

  // ---------------- lookup ----------------
  logic [ADDR_W-1:0]  blk;
  logic [ENTRIES-1:0] match;
  logic               hit_any, idle_any;
  logic [IDX_W-1:0]   hit_idx, idle_idx, lru_idx, used_idx, used_rank;

  assign blk = blk_of(acc_addr);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = ((st_q[i] == ENT_TRAIN) && near_seed(blk, seed_q[i])) ||
                 ((st_q[i] == ENT_WATCH) && inside_win(up_q[i], start_q[i], end_q[i], blk));
    end
  end

  always_comb begin
    hit_any  = 1'b0;
    idle_any = 1'b0;
    hit_idx  = '0;
    idle_idx = '0;
    lru_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (st_q[i] == ENT_IDLE) begin
        idle_any = 1'b1;
        idle_idx = IDX_W'(i);
      end
      if (rank_q[i] == OLDEST) lru_idx = IDX_W'(i);
    end
  end

  assign used_idx  = hit_any ? hit_idx : (idle_any ? idle_idx : lru_idx);
  assign used_rank = rank_q[used_idx];

  // ---------------- named events for the hit entry ----------------
  logic              hit_watch, sel_up, vote_up, votes_agree;
  logic [ADDR_W-1:0] sel_start, sel_end, adv_end, adv_span;

  assign hit_watch   = acc_fire && hit_any && (st_q[hit_idx] == ENT_WATCH);
  assign sel_up      = up_q[hit_idx];
  assign sel_start   = start_q[hit_idx];
  assign sel_end     = end_q[hit_idx];
  assign adv_end     = step_mod(sel_up, sel_end, DEGREE);
  assign adv_span    = sel_up ? (adv_end - sel_start) : (sel_start - adv_end);
  assign vote_up     = blk > seed_q[hit_idx];
  assign votes_agree = vote0_up_q[hit_idx] == vote_up;

  for (genvar d = 0; d < DEGREE; d++) begin : g_burst
    logic [ADDR_W:0] cand;
    assign cand          = step_blk(sel_up, sel_end, d + 1);
    assign burst_vld[d]  = hit_watch && !cand[ADDR_W];
    assign burst_addr[d] = cand[ADDR_W-1:0];
  end

  // ---------------- update ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st_q[i]    <= ENT_IDLE;
        seed_q[i]  <= '0;
        start_q[i] <= '0;
        end_q[i]   <= '0;
        rank_q[i]  <= IDX_W'(i);
      end
      up_q        <= '0;
      vote0_vld_q <= '0;
      vote0_up_q  <= '0;
    end else if (acc_fire) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == used_idx)      rank_q[i] <= '0;
        else if (rank_q[i] < used_rank) rank_q[i] <= rank_q[i] + 1'b1;
      end
      if (!hit_any) begin
        st_q[used_idx]        <= ENT_TRAIN;
        seed_q[used_idx]      <= blk;
        start_q[used_idx]     <= '0;
        end_q[used_idx]       <= '0;
        up_q[used_idx]        <= 1'b0;
        vote0_vld_q[used_idx] <= 1'b0;
        vote0_up_q[used_idx]  <= 1'b0;
      end else if (st_q[hit_idx] == ENT_WATCH) begin
        end_q[hit_idx] <= adv_end;
        if (adv_span > DIST_SPAN) start_q[hit_idx] <= step_mod(sel_up, sel_start, DEGREE);
      end else if (!vote0_vld_q[hit_idx]) begin
        vote0_vld_q[hit_idx] <= 1'b1;
        vote0_up_q[hit_idx]  <= vote_up;
      end else if (votes_agree) begin
        st_q[hit_idx]    <= ENT_WATCH;
        up_q[hit_idx]    <= vote_up;
        start_q[hit_idx] <= seed_q[hit_idx];
        end_q[hit_idx]   <= step_mod(vote_up, blk, DEGREE);
      end else begin
        st_q[hit_idx]        <= ENT_IDLE;
        seed_q[hit_idx]      <= '0;
        vote0_vld_q[hit_idx] <= 1'b0;
        vote0_up_q[hit_idx]  <= 1'b0;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [ENTRIES-1:0] rank_seen;
  logic [IDX_W-1:0]   used_q;

  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < ENTRIES; i++) rank_seen[rank_q[i]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_idx;
  end

  assert_rank_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rank_seen) == ENTRIES);

  assert_used_rank_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (rank_q[used_q] == '0));

endmodule

// File: rtl/spf_burst_fifo.sv
module spf_burst_fifo #(
  parameter int ADDR_W = 32,
  parameter int DEGREE = 4,
  parameter int QDEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DEGREE-1:0]              push_vld,
  input  logic [DEGREE-1:0][ADDR_W-1:0]  push_addr,
  output logic                           space_ok,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [ADDR_W-1:0]              out_addr
);

  localparam int PTR_W = $clog2(QDEPTH);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  function automatic logic [PTR_W-1:0] ring(input logic [PTR_W-1:0] base, input logic [CNT_W-1:0] k);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(base) + (CNT_W+1)'(k);
    if (s >= (CNT_W+1)'(QDEPTH)) s = s - (CNT_W+1)'(QDEPTH);
    return PTR_W'(s);
  endfunction

  logic [ADDR_W-1:0] mem [QDEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  count_q, push_n;
  logic [DEGREE-1:0][CNT_W-1:0] ofs;
  logic              pop;

  // Pack the valid burst slots contiguously behind the write pointer
  always_comb begin
    push_n = '0;
    for (int d = 0; d < DEGREE; d++) begin
      ofs[d] = push_n;
      if (push_vld[d]) push_n = push_n + 1'b1;
    end
  end

  assign out_valid = count_q != '0;
  assign out_addr  = mem[rptr_q];
  assign pop       = out_valid && out_ready;
  assign space_ok  = (CNT_W'(QDEPTH) - count_q) >= CNT_W'(DEGREE);

  always_ff @(posedge clk) begin
    for (int d = 0; d < DEGREE; d++) begin
      if (push_vld[d]) mem[ring(wptr_q, ofs[d])] <= push_addr[d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= ring(wptr_q, push_n);
      rptr_q  <= ring(rptr_q, CNT_W'(pop));
      count_q <= count_q + push_n - CNT_W'(pop);
    end
  end

  assert_fifo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(QDEPTH));

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  assert_fill_after_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q > $past(count_q)) |-> $past(|push_vld));

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 8,
  parameter int DEGREE    = 4,
  parameter int DISTANCE  = 5,
  parameter int BLK_BYTES = 64,
  parameter int QDEPTH    = 2 * DEGREE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);

  logic                          acc_fire, space_ok;
  logic [DEGREE-1:0]             burst_vld;
  logic [DEGREE-1:0][ADDR_W-1:0] burst_addr;

  assign acc_ready = space_ok;
  assign acc_fire  = acc_valid && acc_ready;

  spf_table #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .DEGREE(DEGREE),
    .DISTANCE(DISTANCE), .BLK_BYTES(BLK_BYTES)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .acc_addr(acc_addr),
    .burst_vld(burst_vld), .burst_addr(burst_addr)
  );

  spf_burst_fifo #(
    .ADDR_W(ADDR_W), .DEGREE(DEGREE), .QDEPTH(QDEPTH)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_vld(burst_vld), .push_addr(burst_addr),
    .space_ok(space_ok), .out_valid(pf_valid), .out_ready(pf_ready), .out_addr(pf_addr)
  );

endmodule

// File: tb/tb_stream_prefetcher.sv
`timescale 1ns/1ps
module tb_stream_prefetcher;

  localparam int AW = 32, NE = 8, DEG = 4, DIST = 5, BLK = 64, QD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, pf_ready = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_ready, pf_valid;
  logic [AW-1:0] pf_addr;

  always #2 clk = ~clk;

  stream_prefetcher dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit rnd_rdy = 0, finished = 0;
  bit [31:0] got[$];
  bit [31:0] exp_q[$];

  // ---------------- behavioural table model ----------------
  int        m_st[NE];
  bit [31:0] m_seed[NE], m_start[NE], m_end[NE];
  bit        m_up[NE], m_v0v[NE], m_v0u[NE];
  int        m_rank[NE];

  function automatic void model_reset();
    for (int i = 0; i < NE; i++) begin
      m_st[i] = 0; m_seed[i] = 0; m_start[i] = 0; m_end[i] = 0;
      m_up[i] = 0; m_v0v[i] = 0; m_v0u[i] = 0; m_rank[i] = i;
    end
  endfunction

  function automatic void model_access(bit [31:0] a);
    bit [31:0] b = a & ~32'(BLK - 1);
    int h = -1, u = -1, ru;
    for (int i = 0; i < NE; i++) begin
      if (h < 0) begin
        bit [31:0] df = (b > m_seed[i]) ? b - m_seed[i] : m_seed[i] - b;
        if (m_st[i] == 1 && df <= 32'((DIST / 2) * BLK)) h = i;
        if (m_st[i] == 2 && ((m_up[i] && m_start[i] < b && b < m_end[i]) ||
                             (!m_up[i] && m_start[i] > b && b > m_end[i]))) h = i;
      end
    end
    if (h >= 0) begin
      u = h;
      if (m_st[h] == 2) begin
        bit [31:0] ne, span;
        for (int d = 1; d <= DEG; d++) begin
          longint p = m_up[h] ? longint'(m_end[h]) + d * BLK : longint'(m_end[h]) - d * BLK;
          if (p >= 0 && p <= 64'hFFFF_FFFF) exp_q.push_back(p[31:0]);
        end
        ne   = m_up[h] ? m_end[h] + DEG * BLK : m_end[h] - DEG * BLK;
        span = m_up[h] ? ne - m_start[h] : m_start[h] - ne;
        if (span > 32'(DIST * BLK)) m_start[h] = m_up[h] ? m_start[h] + DEG * BLK : m_start[h] - DEG * BLK;
        m_end[h] = ne;
      end else begin
        bit v = b > m_seed[h];
        if (!m_v0v[h]) begin m_v0v[h] = 1; m_v0u[h] = v; end
        else if (m_v0u[h] == v) begin
          m_st[h] = 2; m_up[h] = v; m_start[h] = m_seed[h];
          m_end[h] = v ? b + DEG * BLK : b - DEG * BLK;
        end else begin
          m_st[h] = 0; m_v0v[h] = 0; m_seed[h] = 0;
        end
      end
    end else begin
      for (int i = 0; i < NE; i++) if (u < 0 && m_st[i] == 0) u = i;
      if (u < 0) for (int i = 0; i < NE; i++) if (m_rank[i] == NE - 1) u = i;
      m_st[u] = 1; m_seed[u] = b; m_start[u] = 0; m_end[u] = 0;
      m_up[u] = 0; m_v0v[u] = 0; m_v0u[u] = 0;
    end
    ru = m_rank[u];
    for (int i = 0; i < NE; i++) if (m_rank[i] < ru) m_rank[i]++;
    m_rank[u] = 0;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, string what, bit [31:0] act, bit [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic check_list(string req, bit [31:0] want[$]);
    check(got.size() == want.size(), req, "prefetch count", got.size(), want.size());
    for (int i = 0; i < want.size() && i < got.size(); i++)
      check(got[i] == want[i], req, $sformatf("prefetch #%0d", i), got[i], want[i]);
  endtask

  always @(negedge clk) if (rst_n && pf_valid && pf_ready) got.push_back(pf_addr);
  always @(posedge clk) if (rnd_rdy) #1 pf_ready = ($urandom % 4) != 0;

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; acc_valid = 0; pf_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    got.delete(); exp_q.delete(); model_reset();
  endtask

  task automatic send(bit [31:0] a);
    acc_valid = 1; acc_addr = a;
    do @(negedge clk); while (!acc_ready);
    model_access(a);
    @(posedge clk); #1 acc_valid = 0;
  endtask

  task automatic settle(); repeat (20) @(posedge clk); #1; endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    bit [31:0] want[$];
    bit [31:0] cur[3];
    bit        dn[3];
    void'($urandom(32'd20240611));

    // R1 reset state
    do_reset();
    @(negedge clk);
    check(pf_valid == 0, "R1", "pf_valid after reset", pf_valid, 0);
    check(acc_ready == 1, "R1", "acc_ready after reset", acc_ready, 1);
    @(posedge clk); #1;

    // R2 R3 R5 R7 R9 ascending stream with unaligned addresses
    send(32'h1005); send(32'h107F); send(32'h1088);
    settle();
    check(got.size() == 0, "R3", "no prefetch while training", got.size(), 0);
    send(32'h10C1);
    send(32'h1280);   // equals end: no hit (R5)
    send(32'h1100);   // equals slid start: no hit (R7)
    settle();
    check(got.size() == 4, "R5 R7", "strict bounds after slide", got.size(), 4);
    send(32'h1141);   // entry 0 and entry 2 both match, entry 0 wins (R9)
    send(32'h1180); send(32'h11C0);
    settle();
    want = '{32'h11C0, 32'h1200, 32'h1240, 32'h1280,
             32'h12C0, 32'h1300, 32'h1340, 32'h1380};
    check_list("R2 R5 R9", want);

    // R6 R10 descending stream reaching address zero
    do_reset();
    send(32'h300); send(32'h2C0); send(32'h280);
    send(32'h240); send(32'h100);
    settle();
    want = '{32'h140, 32'h100, 32'hC0, 32'h80, 32'h40, 32'h0};
    check_list("R6 R10", want);

    // R4 disagreeing votes free the entry
    do_reset();
    send(32'h5000); send(32'h5040); send(32'h4FC0);
    send(32'h5080); send(32'h50C0); send(32'h5100);
    settle();
    check(got.size() == 0, "R4", "no prefetch after rejected training", got.size(), 0);
    send(32'h5140);
    settle();
    want = '{32'h5240, 32'h5280, 32'h52C0, 32'h5300};
    check_list("R4", want);

    // R8 fill all entries then evict the oldest
    do_reset();
    for (int k = 0; k < NE; k++) send(32'((k + 1) << 20));
    send(32'h0010_0040);
    send(32'h0090_0000);     // evicts entry seeded at 0x200000
    send(32'h0010_0080);
    send(32'h0010_00C0);
    send(32'h0090_0040); send(32'h0090_0080); send(32'h0090_00C0);
    settle();
    want = '{32'h0010_01C0, 32'h0010_0200, 32'h0010_0240, 32'h0010_0280,
             32'h0090_01C0, 32'h0090_0200, 32'h0090_0240, 32'h0090_0280};
    check_list("R8", want);

    // R11 backpressure
    do_reset();
    pf_ready = 0;
    send(32'h20000); send(32'h20040); send(32'h20080);
    send(32'h200C0); send(32'h20140);
    @(negedge clk);
    check(acc_ready == 0, "R11", "acc_ready with full buffer", acc_ready, 0);
    check(pf_valid == 1, "R11", "pf_valid while stalled", pf_valid, 1);
    check(pf_addr == 32'h201C0, "R11", "head address", pf_addr, 32'h201C0);
    repeat (3) @(negedge clk);
    check(pf_addr == 32'h201C0, "R11", "head held under stall", pf_addr, 32'h201C0);
    @(posedge clk); #1 pf_ready = 1;
    settle();
    check(acc_ready == 1, "R11", "acc_ready after drain", acc_ready, 1);
    want = '{32'h201C0, 32'h20200, 32'h20240, 32'h20280,
             32'h202C0, 32'h20300, 32'h20340, 32'h20380};
    check_list("R11", want);

    // Random stream walks against the model (R3 R5 R6 R7 R8 R9)
    do_reset();
    for (int k = 0; k < 3; k++) begin cur[k] = 32'h30000 + 32'(k) * 32'h400; dn[k] = k[0]; end
    rnd_rdy = 1;
    for (int n = 0; n < 2500; n++) begin
      int k = $urandom % 3;
      int r = $urandom % 16;
      if (r == 0)      cur[k] = 32'h10000 + 32'($urandom % 4096) * 64;
      else if (r == 1) dn[k] = !dn[k];
      else             cur[k] = dn[k] ? cur[k] - 64 * (1 + (r == 2)) : cur[k] + 64 * (1 + (r == 2));
      send(cur[k] | 32'($urandom % 64));
    end
    rnd_rdy = 0;
    @(posedge clk); #1 pf_ready = 1;
    repeat (40) @(posedge clk); #1;
    check_list("R3 R5 R6 R7 R8 R9 random", exp_q);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule